// File: doc/BRIEF.md
# DMA Region Access Permission Checker

This block decides, for every memory access issued by one of several DMA masters, whether that access may proceed. Software divides the 32-bit address space into 32 programmable regions. Each region is set by an inclusive start page and end page, with 4 KiB granularity. Every master then holds two 32-bit masks, one for reads and one for writes, and bit i of a mask opens region i for that kind of access. After reset every region spans all of memory and every mask is all ones, so nothing is blocked until software narrows the setup.

A small word-addressed register port programs the bounds, the masks and one clock keep-on control bit, and it reads back a fixed version word. The read side is combinational from the address. The check port takes a master index, an address, a direction flag and a valid strobe. It returns a registered verdict one cycle later. An access is granted when at least one region that contains the address carries the permission bit for that master and direction. An access that matches no region, or that comes from a master index outside the configured range, is denied.

Top module: `dma_perm_check`

## Requirements
- R1: After reset every region start bound reads 0 and every end bound reads 0xFFFFF in bits [31:12]. Every read and write mask reads 0xFFFFFFFF. The control word at register index 0x01 reads 1, and register index 0x00 reads the version constant 539165460.
- R2: Region i's start bound is at register index 0x40+2i and its end bound at 0x41+2i. Only write data bits [31:12] are stored, and bits [11:0] always read back as zero.
- R3: An address lies in region i when its page number (address bits [31:12]) is at least the start bound and at most the end bound. Both ends are inclusive.
- R4: A region whose start bound is greater than its end bound contains no address, even when its permission bit is set.
- R5: Master m's read mask is at register index 0x80+2m and its write mask at 0x81+2m. A check with chk_write=1 uses the write mask and chk_write=0 uses the read mask. The access is granted when at least one region containing the address has its mask bit i set.
- R6: An access whose address lies in no region is denied.
- R7: A check whose master index is NUM_MASTERS or greater is always denied.
- R8: res_valid is high exactly in the cycle after a cycle with chk_valid high. While res_valid is high, exactly one of res_grant and res_deny is high, and both are low otherwise.
- R9: A configuration write takes effect for checks presented in the following cycle. A check presented in the same cycle as the write still sees the old setting.
- R10: Writes to index 0x00 are ignored. Index 0x01 stores write data bit 0 and reads it back in bit 0, with all other bits zero.
- R11: Register indices outside the version, control, bound and mask locations read as zero, and writes to them change nothing that can be read back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 8 | Configuration register index |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Configuration read data for cfg_addr (combinational) |
| chk_valid | input | 1 | Access check request strobe |
| chk_master | input | MASTER_IDX_W | Requesting master index |
| chk_addr | input | 32 | Access address |
| chk_write | input | 1 | 1 = write access, 0 = read access |
| res_valid | output | 1 | Verdict valid, one cycle after chk_valid |
| res_grant | output | 1 | Access allowed |
| res_deny | output | 1 | Access refused |

## Verification
The assertions assume that chk_valid is low while reset is applied and that the configuration inputs settle away from the clock edge. The verdict-timing property compares res_valid with the previous cycle's strobe, and it only holds if the first sampled strobe after reset is clean. The stimulus drives every input at the falling edge and keeps chk_valid and cfg_we low through reset and the synchronizer delay. It then sweeps every master index, including two beyond the configured count, over both directions and over pages around each region edge and the empty regions.

// File: rtl/dpc_pkg.sv
package dpc_pkg;
  localparam int unsigned CFG_AW = 8;
  localparam int unsigned DATA_W = 32;
  localparam logic [DATA_W-1:0] VERSION_WORD = 32'd539165460;
  localparam logic [CFG_AW-1:0] IDX_VERSION = 8'h00;
  localparam logic [CFG_AW-1:0] IDX_CLKCTL  = 8'h01;
  localparam logic [CFG_AW-1:0] BASE_BOUND  = 8'h40;
  localparam logic [CFG_AW-1:0] BASE_MASK   = 8'h80;
endpackage

// File: rtl/dpc_bound_bank.sv
module dpc_bound_bank
  import dpc_pkg::*;
#(
  parameter int NR = 32,
  parameter int AW = 32,
  parameter int PW = 20
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [CFG_AW-1:0]        wr_addr,
  input  logic [DATA_W-1:0]        wr_data,
  input  logic [CFG_AW-1:0]        rd_addr,
  output logic                     rd_hit,
  output logic [DATA_W-1:0]        rd_data,
  output logic [NR-1:0][PW-1:0]    lo_q,
  output logic [NR-1:0][PW-1:0]    hi_q
);
  localparam int LSB = AW - PW;
  localparam int IW  = $clog2(NR);
  localparam logic [CFG_AW:0] LIMIT = {1'b0, BASE_BOUND} + (CFG_AW+1)'(2*NR);

  logic [CFG_AW-1:0] wr_off, rd_off;
  logic              wr_in;
  logic [IW-1:0]     wr_idx, rd_idx;
  logic              unused_bits;

  assign wr_off = wr_addr - BASE_BOUND;
  assign rd_off = rd_addr - BASE_BOUND;
  assign wr_in  = (wr_addr >= BASE_BOUND) && ({1'b0, wr_addr} < LIMIT);
  assign rd_hit = (rd_addr >= BASE_BOUND) && ({1'b0, rd_addr} < LIMIT);
  assign wr_idx = wr_off[IW:1];
  assign rd_idx = rd_off[IW:1];
  assign unused_bits = ^{wr_data[LSB-1:0], wr_off[CFG_AW-1:IW+1], rd_off[CFG_AW-1:IW+1]};

  for (genvar g = 0; g < NR; g++) begin : g_region
    logic          lo_en, hi_en;
    logic [PW-1:0] lo_d, hi_d;

    always_comb begin
      lo_en = wr_en && wr_in && (wr_idx == IW'(g)) && !wr_addr[0];
      hi_en = wr_en && wr_in && (wr_idx == IW'(g)) &&  wr_addr[0];
      lo_d  = lo_en ? wr_data[AW-1:LSB] : lo_q[g];
      hi_d  = hi_en ? wr_data[AW-1:LSB] : hi_q[g];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        lo_q[g] <= '0;
        hi_q[g] <= '1;
      end else begin
        lo_q[g] <= lo_d;
        hi_q[g] <= hi_d;
      end
    end

    AST_BOUND_STORE: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_in && (wr_idx == IW'(g)) && !wr_addr[0]) |=> lo_q[g] == $past(wr_data[AW-1:LSB])); // R2
  end

  always_comb begin
    rd_data = '0;
    if (rd_hit) rd_data[AW-1:LSB] = rd_addr[0] ? hi_q[rd_idx] : lo_q[rd_idx];
  end
endmodule

// File: rtl/dpc_mask_bank.sv
module dpc_mask_bank
  import dpc_pkg::*;
#(
  parameter int NM = 8,
  parameter int NR = 32,
  parameter int MW = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [CFG_AW-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [CFG_AW-1:0] rd_addr,
  output logic              rd_hit,
  output logic [DATA_W-1:0] rd_data,
  input  logic [MW-1:0]     sel_master,
  output logic              sel_ok,
  output logic [NR-1:0]     sel_rmask,
  output logic [NR-1:0]     sel_wmask
);
  localparam int IW = $clog2(NM);
  localparam logic [CFG_AW:0] LIMIT = {1'b0, BASE_MASK} + (CFG_AW+1)'(2*NM);

  logic [NM-1:0][NR-1:0] rm_q, wm_q;
  logic [CFG_AW-1:0]     wr_off, rd_off;
  logic                  wr_in;
  logic [IW-1:0]         wr_idx, rd_idx;
  logic                  unused_bits;

  assign wr_off = wr_addr - BASE_MASK;
  assign rd_off = rd_addr - BASE_MASK;
  assign wr_in  = (wr_addr >= BASE_MASK) && ({1'b0, wr_addr} < LIMIT);
  assign rd_hit = (rd_addr >= BASE_MASK) && ({1'b0, rd_addr} < LIMIT);
  assign wr_idx = wr_off[IW:1];
  assign rd_idx = rd_off[IW:1];
  assign unused_bits = ^{wr_data, wr_off[CFG_AW-1:IW+1], rd_off[CFG_AW-1:IW+1]};

  for (genvar m = 0; m < NM; m++) begin : g_master
    logic          rm_en, wm_en;
    logic [NR-1:0] rm_d, wm_d;

    always_comb begin
      rm_en = wr_en && wr_in && (wr_idx == IW'(m)) && !wr_addr[0];
      wm_en = wr_en && wr_in && (wr_idx == IW'(m)) &&  wr_addr[0];
      rm_d  = rm_en ? wr_data[NR-1:0] : rm_q[m];
      wm_d  = wm_en ? wr_data[NR-1:0] : wm_q[m];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        rm_q[m] <= '1;
        wm_q[m] <= '1;
      end else begin
        rm_q[m] <= rm_d;
        wm_q[m] <= wm_d;
      end
    end
  end

  always_comb begin
    rd_data = '0;
    if (rd_hit) rd_data[NR-1:0] = rd_addr[0] ? wm_q[rd_idx] : rm_q[rd_idx];
  end

  always_comb begin
    sel_ok    = 1'b0;
    sel_rmask = '0;
    sel_wmask = '0;
    for (int m = 0; m < NM; m++) begin
      if (sel_master == MW'(m)) begin
        sel_ok    = 1'b1;
        sel_rmask = rm_q[m];
        sel_wmask = wm_q[m];
      end
    end
  end
endmodule

// File: rtl/dpc_region_match.sv
module dpc_region_match #(
  parameter int NR = 32,
  parameter int PW = 20
) (
  input  logic [PW-1:0]          page,
  input  logic [NR-1:0][PW-1:0]  lo_q,
  input  logic [NR-1:0][PW-1:0]  hi_q,
  output logic [NR-1:0]          hit
);
  for (genvar g = 0; g < NR; g++) begin : g_cmp
    logic above_lo, below_hi;
    assign above_lo = (page >= lo_q[g]);
    assign below_hi = (page <= hi_q[g]);
    assign hit[g]   = above_lo && below_hi;
  end
endmodule

// File: rtl/dma_perm_check.sv
module dma_perm_check
  import dpc_pkg::*;
#(
  parameter int NUM_MASTERS  = 8,
  parameter int MASTER_IDX_W = 4,
  parameter int NUM_REGIONS  = 32,
  parameter int ADDR_W       = 32,
  parameter int PAGE_W       = 20
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cfg_we,
  input  logic [7:0]              cfg_addr,
  input  logic [31:0]             cfg_wdata,
  output logic [31:0]             cfg_rdata,
  input  logic                    chk_valid,
  input  logic [MASTER_IDX_W-1:0] chk_master,
  input  logic [31:0]             chk_addr,
  input  logic                    chk_write,
  output logic                    res_valid,
  output logic                    res_grant,
  output logic                    res_deny
);
  localparam int LSB = ADDR_W - PAGE_W;

  // reset: asynchronous assert, synchronous release
  logic rst_meta, rst_sync;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_sync <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_sync <= rst_meta;
    end
  end

  // clock keep-on control bit
  logic clk_keep_q, clk_keep_d, clk_keep_en;
  always_comb begin
    clk_keep_en = cfg_we && (cfg_addr == IDX_CLKCTL);
    clk_keep_d  = clk_keep_en ? cfg_wdata[0] : clk_keep_q;
  end
  always_ff @(posedge clk or negedge rst_sync) begin
    if (!rst_sync) clk_keep_q <= 1'b1;
    else           clk_keep_q <= clk_keep_d;
  end

  // configuration storage
  logic [NUM_REGIONS-1:0][PAGE_W-1:0] lo_q, hi_q;
  logic                               bnd_hit, msk_hit;
  logic [DATA_W-1:0]                  bnd_rdata, msk_rdata;
  logic                               sel_ok;
  logic [NUM_REGIONS-1:0]             sel_rmask, sel_wmask;

  dpc_bound_bank #(.NR(NUM_REGIONS), .AW(ADDR_W), .PW(PAGE_W)) u_bounds (
    .clk(clk), .rst_n(rst_sync),
    .wr_en(cfg_we), .wr_addr(cfg_addr), .wr_data(cfg_wdata),
    .rd_addr(cfg_addr), .rd_hit(bnd_hit), .rd_data(bnd_rdata),
    .lo_q(lo_q), .hi_q(hi_q)
  );

  dpc_mask_bank #(.NM(NUM_MASTERS), .NR(NUM_REGIONS), .MW(MASTER_IDX_W)) u_masks (
    .clk(clk), .rst_n(rst_sync),
    .wr_en(cfg_we), .wr_addr(cfg_addr), .wr_data(cfg_wdata),
    .rd_addr(cfg_addr), .rd_hit(msk_hit), .rd_data(msk_rdata),
    .sel_master(chk_master), .sel_ok(sel_ok),
    .sel_rmask(sel_rmask), .sel_wmask(sel_wmask)
  );

  // configuration read mux
  always_comb begin
    cfg_rdata = '0;
    if (cfg_addr == IDX_VERSION)     cfg_rdata = VERSION_WORD;
    else if (cfg_addr == IDX_CLKCTL) cfg_rdata[0] = clk_keep_q;
    else if (bnd_hit)                cfg_rdata = bnd_rdata;
    else if (msk_hit)                cfg_rdata = msk_rdata;
  end

  // access check
  logic [NUM_REGIONS-1:0] hit, perm;
  logic                   unused_low;
  assign unused_low = ^chk_addr[LSB-1:0];

  dpc_region_match #(.NR(NUM_REGIONS), .PW(PAGE_W)) u_match (
    .page(chk_addr[ADDR_W-1:LSB]), .lo_q(lo_q), .hi_q(hi_q), .hit(hit)
  );

  logic vld_d, grant_d, deny_d;
  always_comb begin
    perm    = chk_write ? sel_wmask : sel_rmask;
    vld_d   = chk_valid;
    grant_d = chk_valid && sel_ok && (|(hit & perm));
    deny_d  = chk_valid && !grant_d;
  end

  always_ff @(posedge clk or negedge rst_sync) begin
    if (!rst_sync) begin
      res_valid <= 1'b0;
      res_grant <= 1'b0;
      res_deny  <= 1'b0;
    end else begin
      res_valid <= vld_d;
      res_grant <= grant_d;
      res_deny  <= deny_d;
    end
  end

  AST_RESULT_LATENCY: assert property (@(posedge clk) disable iff (!rst_sync)
    res_valid == $past(chk_valid)); // R8
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_sync)
    !res_valid |-> (!res_grant && !res_deny)); // R8
  AST_OOR_DENY: assert property (@(posedge clk) disable iff (!rst_sync)
    (chk_valid && (int'(chk_master) >= NUM_MASTERS)) |=> (res_deny && !res_grant)); // R7
  AST_VERSION_FIXED: assert property (@(posedge clk) disable iff (!rst_sync)
    (cfg_addr == IDX_VERSION) |-> (cfg_rdata == VERSION_WORD)); // R10
  AST_CLKCTL_STORE: assert property (@(posedge clk) disable iff (!rst_sync)
    (cfg_we && (cfg_addr == IDX_CLKCTL)) |=> (cfg_addr != IDX_CLKCTL) || (cfg_rdata == {31'd0, $past(cfg_wdata[0])})); // R10
endmodule

// File: tb/tb_dma_perm_check.sv
`timescale 1ns/1ps
module tb_dma_perm_check;
  localparam int NM = 8;
  localparam int NR = 32;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we;
  logic [7:0]  cfg_addr;
  logic [31:0] cfg_wdata;
  logic [31:0] cfg_rdata;
  logic        chk_valid;
  logic [3:0]  chk_master;
  logic [31:0] chk_addr;
  logic        chk_write;
  logic        res_valid, res_grant, res_deny;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  logic [19:0] s_lo [NR];
  logic [19:0] s_hi [NR];
  logic [31:0] s_rm [NM];
  logic [31:0] s_wm [NM];
  logic        s_clk;

  always #2 clk = ~clk;

  dma_perm_check dut (
    .clk(clk), .rst_n(rst_n),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .chk_valid(chk_valid), .chk_master(chk_master), .chk_addr(chk_addr), .chk_write(chk_write),
    .res_valid(res_valid), .res_grant(res_grant), .res_deny(res_deny)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] rotl(logic [31:0] v, int s);
    int k = s % 32;
    return (k == 0) ? v : ((v << k) | (v >> (32 - k)));
  endfunction

  function automatic logic [31:0] model_read(logic [7:0] a);
    if (a == 8'h00) return 32'd539165460;
    if (a == 8'h01) return {31'd0, s_clk};
    if (a >= 8'h40 && a < 8'h80) return a[0] ? {s_hi[(a - 8'h40) >> 1], 12'd0} : {s_lo[(a - 8'h40) >> 1], 12'd0};
    if (a >= 8'h80 && a < 8'h80 + 2*NM) return a[0] ? s_wm[(a - 8'h80) >> 1] : s_rm[(a - 8'h80) >> 1];
    return 32'd0;
  endfunction

  function automatic void model_write(logic [7:0] a, logic [31:0] d);
    if (a == 8'h01) s_clk = d[0];
    else if (a >= 8'h40 && a < 8'h80) begin
      if (a[0]) s_hi[(a - 8'h40) >> 1] = d[31:12];
      else      s_lo[(a - 8'h40) >> 1] = d[31:12];
    end else if (a >= 8'h80 && a < 8'h80 + 2*NM) begin
      if (a[0]) s_wm[(a - 8'h80) >> 1] = d;
      else      s_rm[(a - 8'h80) >> 1] = d;
    end
  endfunction

  // returns {grant, any_region_matched}
  function automatic logic [1:0] model_chk(int m, logic [31:0] a, logic w);
    logic g = 1'b0;
    logic h = 1'b0;
    for (int i = 0; i < NR; i++) begin
      if (a[31:12] >= s_lo[i] && a[31:12] <= s_hi[i]) begin
        h = 1'b1;
        if (m < NM && (w ? s_wm[m][i] : s_rm[m][i])) g = 1'b1;
      end
    end
    return {g, h};
  endfunction

  task automatic cfg_write(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
    model_write(a, d);
  endtask

  task automatic cfg_sweep(string req);
    for (int a = 0; a < 256; a++) begin
      @(negedge clk);
      cfg_addr = a[7:0];
      #0.5;
      if (a >= 2 && a < 8'h40) check("R11 unmapped", cfg_rdata, model_read(a[7:0]));
      else if (a >= 8'h80 + 2*NM) check("R11 unmapped", cfg_rdata, model_read(a[7:0]));
      else check(req, cfg_rdata, model_read(a[7:0]));
    end
  endtask

  task automatic do_chk(int m, logic [31:0] a, logic w);
    logic [1:0] e;
    @(negedge clk);
    chk_valid = 1'b1; chk_master = m[3:0]; chk_addr = a; chk_write = w;
    @(negedge clk);
    e = model_chk(m, a, w);
    if (m >= NM)   check("R7 out-of-range master", {29'd0, res_valid, res_grant, res_deny}, 32'b101);
    else if (!e[0] && !e[1]) check("R6 no region", {29'd0, res_valid, res_grant, res_deny}, 32'b101);
    else check("R3 R5 region grant", {29'd0, res_valid, res_grant, res_deny}, {29'd0, 1'b1, e[1] & e[0], !(e[1] & e[0])});
  endtask

  initial begin
    #400000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NR; i++) begin s_lo[i] = '0; s_hi[i] = '1; end
    for (int m = 0; m < NM; m++) begin s_rm[m] = '1; s_wm[m] = '1; end
    s_clk = 1'b1;
    rst_n = 1'b0; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
    chk_valid = 1'b0; chk_master = '0; chk_addr = '0; chk_write = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset values and R8 idle outputs
    check("R8 idle after reset", {29'd0, res_valid, res_grant, res_deny}, 32'd0);
    cfg_sweep("R1 reset value");

    // R2 low bits dropped, R10 version and control bit, R11 unmapped writes
    cfg_write(8'h40, 32'h12345ABC);
    @(negedge clk); cfg_addr = 8'h40; #0.5;
    check("R2 bound low bits", cfg_rdata, 32'h12345000);
    cfg_write(8'h00, 32'h0);
    @(negedge clk); cfg_addr = 8'h00; #0.5;
    check("R10 version write ignored", cfg_rdata, 32'd539165460);
    cfg_write(8'h01, 32'hFFFF_FFFE);
    @(negedge clk); cfg_addr = 8'h01; #0.5;
    check("R10 control bit clear", cfg_rdata, 32'd0);
    cfg_write(8'h01, 32'h0000_0003);
    @(negedge clk); cfg_addr = 8'h01; #0.5;
    check("R10 control bit set", cfg_rdata, 32'd1);
    cfg_write(8'h20, 32'hFFFF_FFFF);
    cfg_write(8'hF0, 32'hFFFF_FFFF);

    // program regions
    for (int i = 0; i < 24; i++) begin
      cfg_write(8'h40 + 2*i, (i*12) << 12);
      cfg_write(8'h41 + 2*i, (i*12 + (i%5)*3) << 12);
    end
    for (int i = 24; i < 28; i++) begin
      cfg_write(8'h40 + 2*i, 500 << 12);
      cfg_write(8'h41 + 2*i, 400 << 12);
    end
    cfg_write(8'h40 + 56, 32'hFFFF0000); cfg_write(8'h41 + 56, 32'hFFFFF000);
    cfg_write(8'h40 + 58, 32'h80000000); cfg_write(8'h41 + 58, 32'h80000000);
    cfg_write(8'h40 + 60, 600 << 12);    cfg_write(8'h41 + 60, 599 << 12);
    cfg_write(8'h40 + 62, 32'hFFFFF000); cfg_write(8'h41 + 62, 32'h00000000);
    for (int m = 0; m < NM; m++) begin
      cfg_write(8'h80 + 2*m, rotl(32'hA5C396F1, m*5));
      cfg_write(8'h81 + 2*m, ~rotl(32'h3C5A69E7, m*7) ^ (32'h0F0F0F0F << m));
    end
    cfg_sweep("R2 R5 register map readback");

    // sweep of masters, directions and pages
    for (int m = 0; m < NM + 2; m++) begin
      for (int w = 0; w < 2; w++) begin
        for (int p = 0; p < 300; p++) do_chk(m, (p << 12) | ((p*37) & 12'hFFF), w[0]);
        do_chk(m, 32'h7FFFF000, w[0]);
        do_chk(m, 32'h80000ABC, w[0]);
        do_chk(m, 32'h80001000, w[0]);
        do_chk(m, 32'hFFFEFFFF, w[0]);
        do_chk(m, 32'hFFFF0000, w[0]);
        do_chk(m, 32'hFFFFFFFF, w[0]);
        do_chk(m, 450 << 12, w[0]);
        do_chk(m, 599 << 12, w[0]);
        do_chk(m, 600 << 12, w[0]);
      end
    end

    // R4: only an inverted region permitted, address between its bounds
    cfg_write(8'h81, 32'h0100_0000);
    do_chk(0, 450 << 12, 1'b1);
    @(negedge clk); chk_valid = 1'b1; chk_master = 4'd0; chk_addr = 450 << 12; chk_write = 1'b1;
    @(negedge clk);
    check("R4 empty region denies", {29'd0, res_valid, res_grant, res_deny}, 32'b101);

    // R3 inclusive edges with a single-region mask
    cfg_write(8'h82, 32'h0000_0004);
    do_chk(1, 23 << 12, 1'b0);
    check("R3 below start", {31'd0, res_grant}, 32'd0);
    do_chk(1, 24 << 12, 1'b0);
    check("R3 start page", {31'd0, res_grant}, 32'd1);
    do_chk(1, (30 << 12) | 12'hFFF, 1'b0);
    check("R3 end page", {31'd0, res_grant}, 32'd1);
    do_chk(1, 31 << 12, 1'b0);
    check("R3 above end", {31'd0, res_grant}, 32'd0);

    // R9 write and check in the same cycle
    cfg_write(8'h82, 32'hFFFF_FFFF);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 8'h82; cfg_wdata = 32'h0;
    chk_valid = 1'b1; chk_master = 4'd1; chk_addr = 12 << 12; chk_write = 1'b0;
    @(negedge clk);
    cfg_we = 1'b0;
    check("R9 same-cycle check uses old mask", {29'd0, res_valid, res_grant, res_deny}, 32'b110);
    model_write(8'h82, 32'h0);
    @(negedge clk);
    check("R9 next check uses new mask", {29'd0, res_valid, res_grant, res_deny}, 32'b101);

    // R8 idle after strobe drops
    chk_valid = 1'b0;
    @(negedge clk);
    check("R8 idle after strobe", {29'd0, res_valid, res_grant, res_deny}, 32'd0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule